// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Sequencer

This block sits between a synchronous system clock domain and an external asynchronous static RAM organised as 128K words of 8 bits. A client offers a read or write request for one cycle. When the block is idle it accepts the request and plays out a fixed sequence of chip-select, output-enable and write-enable levels on the memory pins. Each phase of that sequence lasts a whole number of clock cycles. That number is derived at elaboration from nanosecond timing parameters and the clock period.

Reads keep chip select and output enable low for the access time or the read cycle time, whichever is longer. The returned byte is registered at the end of the access phase and handed back with a single-cycle valid pulse. Writes end on the rising edge of write enable, with chip select held low across the pulse and output enable high for the whole write. The block's own data driver turns on only after the memory's outputs have had a cycle to release the bus, and it turns off again before output enable can fall. While a sequence runs, the block reports busy and drops its ready flag. Any request offered in that time is dropped.

Top module: `sram_seq_ctrl`

## Requirements
- R1: After reset and whenever the block is idle, chip select, output enable and write enable are high (inactive), the data driver enable is low, busy is low and req_ready is high.
- R2: Every phase length is ceil(T_ns / CLK_PERIOD_NS), and never less than 1 cycle.
- R3: A read keeps chip select and output enable low, and write enable high, for max(access cycles, read-cycle cycles) consecutive cycles. These start the cycle after acceptance.
- R4: The read byte is the value on sram_dq_in during the last access cycle (cycle number access-cycles after acceptance). rd_valid is high for exactly one cycle, the one after that, with rd_data holding the byte.
- R5: A write holds chip select low and output enable high throughout. Write enable stays high for TURN_CYC cycles, then goes low for max(write-pulse, data-setup, address-setup minus TURN_CYC) cycles.
- R6: sram_dq_oe is high from the first write-enable-low cycle to the end of the write (pulse plus recovery cycles). It is never high while output enable is low, and it rises only after a cycle with output enable high.
- R7: For the whole of a sequence, sram_addr holds the accepted address, and during a write sram_dq_out holds the accepted data.
- R8: busy is high from the cycle after acceptance until the sequence ends, and req_ready is its complement. A request presented while busy has no effect on the pins or on the memory contents.
- R9: The write recovery phase lasts max(1, write-cycle cycles minus turnaround minus pulse). A new request is accepted in the first idle cycle after a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken only when req_ready is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address of the request |
| req_wdata | input | 8 | Byte to write |
| req_ready | output | 1 | High when a request will be accepted |
| busy | output | 1 | High while a strobe sequence is running |
| rd_data | output | 8 | Byte returned by the last read |
| rd_valid | output | 1 | One-cycle pulse marking rd_data as new |
| sram_addr | output | 17 | Address pins of the memory |
| sram_cs_n | output | 1 | Chip select, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_dq_out | output | 8 | Data toward the memory |
| sram_dq_oe | output | 1 | Enable of the data driver toward the memory |
| sram_dq_in | input | 8 | Data from the memory pins |

## Verification
The assertions assume the client changes req_addr, req_wdata and req_write only in ways that matter at an accepting edge. They also assume the memory returns valid data no later than the access phase's last cycle. The bench memory model meets this by presenting a poison byte until output enable has been low for the computed number of access cycles. The bench issues requests only at falling edges. In the busy-request case it deliberately holds a conflicting request for the whole sequence, but drops it in the first idle cycle, so it is never accepted later by accident.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_READ   = 3'd1,
        ST_WTURN  = 3'd2,
        ST_WPULSE = 3'd3,
        ST_WREC   = 3'd4
    } ctl_state_e;

    typedef struct packed {
        logic cs_n;
        logic oe_n;
        logic we_n;
        logic drive;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{cs_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};

    // Whole cycles covering a nanosecond figure, at least one.
    function automatic int unsigned cyc_of(input int unsigned ns, input int unsigned period);
        int unsigned r;
        r = (ns + period - 1) / period;
        return (r == 0) ? 1 : r;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic strobe_t strobe_of(input ctl_state_e st);
        strobe_t s;
        s = STROBE_IDLE;
        case (st)
            ST_READ:   begin s.cs_n = 1'b0; s.oe_n = 1'b0; end
            ST_WTURN:  begin s.cs_n = 1'b0; end
            ST_WPULSE: begin s.cs_n = 1'b0; s.we_n = 1'b0; s.drive = 1'b1; end
            ST_WREC:   begin s.cs_n = 1'b0; s.drive = 1'b1; end
            default:   s = STROBE_IDLE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    output logic [CNT_W-1:0] elapsed
);
    always_ff @(posedge clk) begin
        if (rst || restart) begin
            elapsed <= '0;
        end else begin
            elapsed <= elapsed + 1'b1;
        end
    end
endmodule

// File: rtl/sram_strobe_gen.sv
module sram_strobe_gen
    import sram_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  ctl_state_e state_d,
    output logic       cs_n,
    output logic       oe_n,
    output logic       we_n,
    output logic       drive
);
    strobe_t strobe_q;

    // Pins come straight from flops so they cannot glitch.
    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= STROBE_IDLE;
        end else begin
            strobe_q <= strobe_of(state_d);
        end
    end

    assign cs_n  = strobe_q.cs_n;
    assign oe_n  = strobe_q.oe_n;
    assign we_n  = strobe_q.we_n;
    assign drive = strobe_q.drive;

    // R5: write enable low only with chip select low and outputs disabled
    assert_write_oe_high_R5: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> (oe_n && !cs_n));

    // R6: the driver never fights the memory's outputs
    assert_no_contention_R6: assert property (@(posedge clk) disable iff (rst)
        drive |-> oe_n);
endmodule

// File: rtl/sram_read_capture.sv
module sram_read_capture #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= capture;
            if (capture) begin
                rd_data <= dq_in;
            end
        end
    end

    // R4: valid is a single-cycle pulse
    assert_rdvalid_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);
endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
    import sram_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W        = 17,
    parameter int unsigned DATA_W        = 8,
    parameter int unsigned CLK_PERIOD_NS = 20,
    parameter int unsigned T_RC_NS       = 15,
    parameter int unsigned T_AA_NS       = 15,
    parameter int unsigned T_WC_NS       = 15,
    parameter int unsigned T_WP_NS       = 12,
    parameter int unsigned T_AW_NS       = 12,
    parameter int unsigned T_DW_NS       = 7,
    parameter int unsigned TURN_CYC      = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              busy,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_cs_n,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_in
);
    localparam int unsigned N_AA    = cyc_of(T_AA_NS, CLK_PERIOD_NS);
    localparam int unsigned N_RC    = cyc_of(T_RC_NS, CLK_PERIOD_NS);
    localparam int unsigned N_WC    = cyc_of(T_WC_NS, CLK_PERIOD_NS);
    localparam int unsigned N_WP    = cyc_of(T_WP_NS, CLK_PERIOD_NS);
    localparam int unsigned N_AW    = cyc_of(T_AW_NS, CLK_PERIOD_NS);
    localparam int unsigned N_DW    = cyc_of(T_DW_NS, CLK_PERIOD_NS);
    localparam int unsigned N_RD    = max2(N_AA, N_RC);
    localparam int unsigned N_TURN  = max2(TURN_CYC, 1);
    localparam int unsigned N_AWREM = (N_AW > N_TURN) ? (N_AW - N_TURN) : 1;
    localparam int unsigned N_PULSE = max2(max2(N_WP, N_DW), N_AWREM);
    localparam int unsigned N_REC   = (N_WC > N_TURN + N_PULSE + 1) ? (N_WC - N_TURN - N_PULSE) : 1;
    localparam int unsigned N_MAX   = max2(max2(N_RD, N_TURN), max2(N_PULSE, N_REC));
    localparam int unsigned CNT_W   = $clog2(N_MAX + 1);

    localparam logic [CNT_W-1:0] AA_M1    = CNT_W'(N_AA - 1);
    localparam logic [CNT_W-1:0] RD_M1    = CNT_W'(N_RD - 1);
    localparam logic [CNT_W-1:0] TURN_M1  = CNT_W'(N_TURN - 1);
    localparam logic [CNT_W-1:0] PULSE_M1 = CNT_W'(N_PULSE - 1);
    localparam logic [CNT_W-1:0] REC_M1   = CNT_W'(N_REC - 1);

    ctl_state_e        state_q, state_d;
    logic [CNT_W-1:0]  elapsed;
    logic              restart;
    logic              capture;
    logic              accept;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    assign busy      = (state_q != ST_IDLE);
    assign req_ready = !busy;
    assign accept    = req_valid && (state_q == ST_IDLE);

    always_comb begin
        state_d = state_q;
        capture = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d = req_write ? ST_WTURN : ST_READ;
                end
            end
            ST_READ: begin
                capture = (elapsed == AA_M1);
                if (elapsed == RD_M1) begin
                    state_d = ST_IDLE;
                end
            end
            ST_WTURN: begin
                if (elapsed == TURN_M1) begin
                    state_d = ST_WPULSE;
                end
            end
            ST_WPULSE: begin
                if (elapsed == PULSE_M1) begin
                    state_d = ST_WREC;
                end
            end
            ST_WREC: begin
                if (elapsed == REC_M1) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign restart = (state_d != state_q) || (state_q == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
        end
    end

    assign sram_addr   = addr_q;
    assign sram_dq_out = wdata_q;

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .elapsed (elapsed)
    );

    sram_strobe_gen u_strobe (
        .clk     (clk),
        .rst     (rst),
        .state_d (state_d),
        .cs_n    (sram_cs_n),
        .oe_n    (sram_oe_n),
        .we_n    (sram_we_n),
        .drive   (sram_dq_oe)
    );

    sram_read_capture #(.DATA_W(DATA_W)) u_capture (
        .clk      (clk),
        .rst      (rst),
        .capture  (capture),
        .dq_in    (sram_dq_in),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    // R1: idle means every strobe inactive and the bus released
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (sram_cs_n && sram_oe_n && sram_we_n && !sram_dq_oe));

    // R8: an accepted request makes the block busy on the next cycle
    assert_accept_busy_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> busy);

    // R7: address pins stay put while a sequence continues
    assert_addr_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(sram_addr));

    // R6: the driver turns on only after output enable has been high a cycle
    assert_turnaround_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_dq_oe) |-> ($past(sram_oe_n) && sram_oe_n));
endmodule

// File: tb/sram_seq_ctrl_bench.sv
module sram_seq_ctrl_bench;
    localparam int PER    = 20;
    localparam int T_AA   = 55;
    localparam int T_RC   = 75;
    localparam int T_WC   = 115;
    localparam int T_WP   = 45;
    localparam int T_AW   = 45;
    localparam int T_DW   = 25;
    localparam int TURN   = 1;

    function automatic int cyc(input int ns);
        int r;
        r = (ns + PER - 1) / PER;
        return (r < 1) ? 1 : r;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int E_AA    = cyc(T_AA);
    localparam int E_RD    = mx(E_AA, cyc(T_RC));
    localparam int E_PULSE = mx(mx(cyc(T_WP), cyc(T_DW)), mx(cyc(T_AW) - TURN, 1));
    localparam int E_REC   = mx(1, cyc(T_WC) - TURN - E_PULSE);
    localparam int E_WR    = TURN + E_PULSE + E_REC;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, busy, rd_valid;
    logic [7:0]  rd_data;
    logic [16:0] sram_addr;
    logic        sram_cs_n, sram_oe_n, sram_we_n, sram_dq_oe;
    logic [7:0]  sram_dq_out;
    logic [7:0]  sram_dq_in;

    always #10 clk = ~clk;

    sram_seq_ctrl #(
        .CLK_PERIOD_NS(PER), .T_RC_NS(T_RC), .T_AA_NS(T_AA), .T_WC_NS(T_WC),
        .T_WP_NS(T_WP), .T_AW_NS(T_AW), .T_DW_NS(T_DW), .TURN_CYC(TURN)
    ) u_sram_seq_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .busy(busy), .rd_data(rd_data), .rd_valid(rd_valid),
        .sram_addr(sram_addr), .sram_cs_n(sram_cs_n), .sram_oe_n(sram_oe_n),
        .sram_we_n(sram_we_n), .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe),
        .sram_dq_in(sram_dq_in)
    );

    // Memory model: low address byte selects the cell; poison until access time met.
    logic [7:0] mem [256];
    logic [7:0] shadow [256];
    int rd_run = 0;
    int hazard = 0;
    logic prev_we = 1'b1;
    int n_chk = 0;
    int n_fail = 0;

    assign sram_dq_in = (rd_run >= E_AA) ? mem[sram_addr[7:0]] : 8'hEE;

    always @(negedge clk) begin
        if (!sram_cs_n && !sram_oe_n && sram_we_n) rd_run <= rd_run + 1;
        else rd_run <= 0;
        if (!sram_oe_n && sram_dq_oe) hazard <= hazard + 1;
        if (!prev_we && sram_we_n && !sram_cs_n) begin
            mem[sram_addr[7:0]] <= sram_dq_out;
            if (!sram_dq_oe) hazard <= hazard + 1;
        end
        prev_we <= sram_we_n;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_txn(input bit wr, input logic [16:0] a, input logic [7:0] d, input bit poke);
        int n = 0, cs = 0, oe = 0, we = 0, drv = 0, bad = 0, rv_idx = -1, first_we = -1, rv_cnt = 0;
        int idx;
        logic [7:0] got = 8'h00;
        @(negedge clk);
        check(req_ready === 1'b1, "R8 ready before request", req_ready, 1);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        if (poke) begin
            req_write = 1'b1; req_addr = a ^ 17'h000F0; req_wdata = ~d;
        end else begin
            req_valid = 1'b0;
        end
        idx = 1;
        while (busy && idx < 40) begin
            n++;
            if (!sram_cs_n) cs++;
            if (!sram_oe_n) oe++;
            if (!sram_we_n) begin we++; if (first_we < 0) first_we = idx; end
            if (sram_dq_oe) drv++;
            if (sram_addr !== a) bad++;
            if (wr && sram_dq_oe && sram_dq_out !== d) bad++;
            if (rd_valid) begin rv_idx = idx; got = rd_data; rv_cnt++; end
            idx++;
            @(negedge clk);
        end
        req_valid = 1'b0;
        if (rd_valid) begin rv_idx = idx; got = rd_data; rv_cnt++; end
        check(sram_cs_n && sram_oe_n && sram_we_n && !sram_dq_oe, "R1 idle after sequence", sram_cs_n, 1);
        check(bad == 0, "R7 address/data held", bad, 0);
        if (wr) begin
            shadow[a[7:0]] = d;
            check(n == E_WR, "R8 write busy length", n, E_WR);
            check(cs == E_WR && oe == 0, "R5 write cs/oe cycles", cs * 100 + oe, E_WR * 100);
            check(we == E_PULSE && first_we == TURN + 1, "R5 write pulse", we * 100 + first_we, E_PULSE * 100 + TURN + 1);
            check(drv == E_PULSE + E_REC, "R6 driver cycles", drv, E_PULSE + E_REC);
            check(E_REC == cyc(T_WC) - TURN - E_PULSE || E_REC == 1, "R9 recovery length", E_REC, E_REC);
            check(rv_cnt == 0, "R4 no valid on write", rv_cnt, 0);
        end else begin
            check(n == E_RD, "R8 read busy length", n, E_RD);
            check(cs == E_RD && oe == E_RD && we == 0, "R3 read strobes", cs * 100 + oe, E_RD * 101);
            check(rv_idx == E_AA + 1 && rv_cnt == 1, "R4 valid timing", rv_idx, E_AA + 1);
            check(got == shadow[a[7:0]], "R4 read data", got, shadow[a[7:0]]);
        end
    endtask

    initial begin
        #(20 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'(i) ^ 8'h5A;
            shadow[i] = 8'(i) ^ 8'h5A;
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(sram_cs_n && sram_oe_n && sram_we_n && !sram_dq_oe && !busy && req_ready,
              "R1 reset state", {sram_cs_n, sram_oe_n, sram_we_n, sram_dq_oe, busy, req_ready}, 6'b111001);
        // R2: the derived phase lengths for this configuration
        check(E_AA == 3 && E_RD == 4 && E_PULSE == 3 && E_REC == 2, "R2 phase arithmetic",
              E_AA * 1000 + E_RD * 100 + E_PULSE * 10 + E_REC, 3432);
        // Reads of untouched cells
        for (int i = 0; i < 4; i++) run_txn(1'b0, 17'(i * 'h2101), 8'h00, 1'b0);
        // Write sweep then read back
        for (int i = 0; i < 16; i++) run_txn(1'b1, 17'(i * 'h2101), 8'(i * 37 + 3), 1'b0);
        for (int i = 0; i < 16; i++) run_txn(1'b0, 17'(i * 'h2101), 8'h00, 1'b0);
        // R9: alternating back-to-back reads and writes
        for (int i = 16; i < 24; i++) begin
            run_txn(1'b1, 17'(i * 'h0301), 8'(255 - i), 1'b0);
            run_txn(1'b0, 17'(i * 'h0301), 8'h00, 1'b0);
        end
        // R8: requests held while busy are ignored
        run_txn(1'b1, 17'h1_2340, 8'hC3, 1'b1);
        run_txn(1'b0, 17'h1_2340, 8'h00, 1'b1);
        run_txn(1'b0, 17'h1_2340 ^ 17'h000F0, 8'h00, 1'b0);
        check(mem[8'h40 ^ 8'hF0] == shadow[8'h40 ^ 8'hF0], "R8 poke did not write",
              mem[8'h40 ^ 8'hF0], shadow[8'h40 ^ 8'hF0]);
        check(hazard == 0, "R6 bus contention or hold", hazard, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule